// File: doc/BRIEF.md
# Zero-Address Stack Machine Core

This block is a small processor with no register operands. Every arithmetic and logic instruction takes its inputs from the top of an internal operand stack and pushes its result back onto that stack. A separate file of addressable storage slots holds values across a computation. Values reach that file only through an explicit store, which pops the stack, and come back through a load, which pushes. The core reads its instructions from an internal program memory that is filled through a write port while the core is held idle. Branches go to absolute addresses. One input stream port and one output stream port move data into and out of the computation.

Each cycle in which `run` is high and the core is not halted, the core executes one instruction. The only exception is a read that waits for input. The top of the stack sits in a register, and the element below it is read from a small array, so every instruction completes in one cycle. A stack fault or an unknown opcode stops the core with an error code. Division or remainder by zero pushes zero and sets a sticky flag. The core remains halted until reset.

Top module: `smc_core`

## Requirements
- R1: After reset, `halted`, `err_code`, `stk_level`, `out_valid`, `in_take` and `div_zero` are all zero, and every storage slot holds zero.
- R2: An instruction word is `{op[4:0], arg[W-1:0]}`. The opcodes are: NOP=0, PUSH=1, ADD=2, SUB=3, AND=4, OR=5, LT=6, EQ=7, DIV=8, MOD=9, NEG=10, NOT=11, DUP=12, SWAP=13, JZ=14, JMP=15, LDS=16, STS=17, RD=18, WR=19, HALT=20. PUSH pushes `arg` unchanged.
- R3: A binary operation pops y (the top), then pops x, then pushes x op y. This covers ADD, SUB (x-y, modulo 2^W), AND, OR, LT (unsigned x<y gives 1, otherwise 0) and EQ (1 if equal, otherwise 0). Each such operation lowers the depth by one.
- R4: DIV and MOD push the unsigned quotient and the remainder of x by y. When y is zero they push 0 and set `div_zero`, which stays set until reset.
- R5: NEG replaces the top with its two's-complement negation, and NOT replaces it with its bitwise inverse. Depth does not change.
- R6: DUP pushes a copy of the top. SWAP exchanges the top two entries.
- R7: JZ pops the top and jumps to address `arg` if the popped value was zero; otherwise it falls through. JMP always jumps to `arg`. Neither form is relative.
- R8: STS pops the top into the slot numbered by the low bits of `arg`. LDS pushes that slot's value and leaves the slot unchanged.
- R9: RD waits while `in_valid` is low. It pushes `in_data` in the cycle where `in_take` is high, and `in_take` is only high when `in_valid` is high. WR pops the top and presents it on `out_data`, with `out_valid` high for the single following cycle.
- R10: HALT stops execution with `err_code` 0. Once `halted` is high it stays high until reset, and no further instruction takes effect.
- R11: An instruction that needs more entries than the stack holds halts the core with `err_code` 1 and changes nothing else.
- R12: An instruction that would grow a full stack halts the core with `err_code` 2 and changes nothing else. `stk_level` never exceeds DEPTH. A RD on a full stack never asserts `in_take`, even when `in_valid` is high.
- R13: An opcode outside the list in R2 halts the core with `err_code` 3.
- R14: While `run` is low, no instruction executes and the stack depth holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Program memory write strobe |
| prog_addr | input | $clog2(PDEPTH) | Program memory write address |
| prog_data | input | 5+W | Instruction word to write |
| run | input | 1 | Execute enable |
| in_valid | input | 1 | Input stream has a value |
| in_data | input | W | Input stream value |
| in_take | output | 1 | Input value consumed this cycle |
| out_valid | output | 1 | Output stream value present |
| out_data | output | W | Output stream value |
| halted | output | 1 | Core has stopped |
| err_code | output | 2 | 0 none, 1 underflow, 2 overflow, 3 illegal opcode |
| div_zero | output | 1 | Sticky divide-by-zero flag |
| stk_level | output | $clog2(DEPTH+1) | Current stack depth |

## Verification
The two functions that can meet in one cycle are the input wait of RD and the overflow check. A RD that reaches a full stack both waits for input and faults, and the fault has to win without consuming any input. The bench fills the stack to DEPTH with PUSH, places RD next, and holds `in_valid` high throughout. It then judges that `in_take` never rose, that `err_code` is 2, and that the depth stayed at DEPTH. The complementary case is a RD on an empty stack with no input: the core must stall with no fault and no change of depth, which is checked before input is supplied.

// File: rtl/smc_pkg.sv
package smc_pkg;

  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_NOP  = 5'd0,  OP_PUSH = 5'd1,  OP_ADD  = 5'd2,  OP_SUB  = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_LT   = 5'd6,  OP_EQ   = 5'd7,
    OP_DIV  = 5'd8,  OP_MOD  = 5'd9,  OP_NEG  = 5'd10, OP_NOT  = 5'd11,
    OP_DUP  = 5'd12, OP_SWAP = 5'd13, OP_JZ   = 5'd14, OP_JMP  = 5'd15,
    OP_LDS  = 5'd16, OP_STS  = 5'd17, OP_RD   = 5'd18, OP_WR   = 5'd19,
    OP_HALT = 5'd20
  } opcode_e;

  // stack movement requested by an instruction
  typedef enum logic [2:0] {
    SK_HOLD,   // no change
    SK_PUSH,   // old top sinks, new top = data
    SK_POP,    // second entry rises to top
    SK_SET,    // top replaced
    SK_MERGE,  // two entries become one (new top = data)
    SK_SWAP    // top two exchanged
  } stk_act_e;

  typedef enum logic [2:0] {
    RS_IMM, RS_ALU, RS_SLOT, RS_IN, RS_TOS
  } res_sel_e;

  typedef enum logic [3:0] {
    AL_ADD, AL_SUB, AL_AND, AL_OR, AL_LT, AL_EQ,
    AL_DIV, AL_MOD, AL_NEG, AL_NOT
  } alu_fn_e;

  typedef enum logic [1:0] {
    ERR_NONE    = 2'd0,
    ERR_UNDER   = 2'd1,
    ERR_OVER    = 2'd2,
    ERR_ILLEGAL = 2'd3
  } err_e;

  typedef struct packed {
    logic       legal;
    logic [1:0] n_in;   // entries consumed
    logic [1:0] n_out;  // entries produced
    stk_act_e   act;
    res_sel_e   rsel;
    alu_fn_e    fn;
    logic       jz;
    logic       jmp;
    logic       sts;
    logic       rd;
    logic       wr;
    logic       halt;
  } dec_t;

endpackage

// File: rtl/smc_decode.sv
module smc_decode
  import smc_pkg::*;
(
  input  logic [OPW-1:0] op,
  output dec_t           dec
);

  always_comb begin
    dec       = '0;
    dec.legal = 1'b1;
    dec.act   = SK_HOLD;
    dec.rsel  = RS_ALU;
    dec.fn    = AL_ADD;
    unique case (op)
      OP_NOP: ;
      OP_PUSH: begin
        dec.n_out = 2'd1; dec.act = SK_PUSH; dec.rsel = RS_IMM;
      end
      OP_ADD, OP_SUB, OP_AND, OP_OR, OP_LT, OP_EQ, OP_DIV, OP_MOD: begin
        dec.n_in = 2'd2; dec.n_out = 2'd1; dec.act = SK_MERGE;
        unique case (op)
          OP_ADD:  dec.fn = AL_ADD;
          OP_SUB:  dec.fn = AL_SUB;
          OP_AND:  dec.fn = AL_AND;
          OP_OR:   dec.fn = AL_OR;
          OP_LT:   dec.fn = AL_LT;
          OP_EQ:   dec.fn = AL_EQ;
          OP_DIV:  dec.fn = AL_DIV;
          default: dec.fn = AL_MOD;
        endcase
      end
      OP_NEG, OP_NOT: begin
        dec.n_in = 2'd1; dec.n_out = 2'd1; dec.act = SK_SET;
        dec.fn   = (op == OP_NEG) ? AL_NEG : AL_NOT;
      end
      OP_DUP: begin
        dec.n_in = 2'd1; dec.n_out = 2'd2; dec.act = SK_PUSH; dec.rsel = RS_TOS;
      end
      OP_SWAP: begin
        dec.n_in = 2'd2; dec.n_out = 2'd2; dec.act = SK_SWAP;
      end
      OP_JZ: begin
        dec.n_in = 2'd1; dec.act = SK_POP; dec.jz = 1'b1;
      end
      OP_JMP: dec.jmp = 1'b1;
      OP_LDS: begin
        dec.n_out = 2'd1; dec.act = SK_PUSH; dec.rsel = RS_SLOT;
      end
      OP_STS: begin
        dec.n_in = 2'd1; dec.act = SK_POP; dec.sts = 1'b1;
      end
      OP_RD: begin
        dec.n_out = 2'd1; dec.act = SK_PUSH; dec.rsel = RS_IN; dec.rd = 1'b1;
      end
      OP_WR: begin
        dec.n_in = 2'd1; dec.act = SK_POP; dec.wr = 1'b1;
      end
      OP_HALT: dec.halt = 1'b1;
      default: dec.legal = 1'b0;
    endcase
  end

endmodule

// File: rtl/smc_alu.sv
module smc_alu
  import smc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x,    // second entry
  input  logic [W-1:0] y,    // top entry
  input  alu_fn_e      fn,
  output logic [W-1:0] res,
  output logic         dz
);

  logic y_zero;
  assign y_zero = (y == '0);

  always_comb begin
    res = '0;
    dz  = 1'b0;
    unique case (fn)
      AL_ADD: res = x + y;
      AL_SUB: res = x - y;
      AL_AND: res = x & y;
      AL_OR:  res = x | y;
      AL_LT:  res[0] = (x < y);
      AL_EQ:  res[0] = (x == y);
      AL_DIV: begin
        dz  = y_zero;
        res = y_zero ? '0 : x / y;
      end
      AL_MOD: begin
        dz  = y_zero;
        res = y_zero ? '0 : x % y;
      end
      AL_NEG: res = '0 - y;
      AL_NOT: res = ~y;
      default: res = '0;
    endcase
  end

endmodule

// File: rtl/smc_stack.sv
module smc_stack
  import smc_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  stk_act_e                   act,
  input  logic [W-1:0]               din,
  output logic [W-1:0]               tos,
  output logic [W-1:0]               nos,
  output logic [$clog2(DEPTH+1)-1:0] level
);

  localparam int LVW = $clog2(DEPTH+1);
  localparam int BD  = DEPTH - 1;          // entries below the top register
  localparam int BIW = (BD > 1) ? $clog2(BD) : 1;

  logic [W-1:0]   below [BD];
  logic [W-1:0]   tos_q, tos_d;
  logic [LVW-1:0] lvl_q, lvl_d;
  logic           wr_en;
  logic [BIW-1:0] wr_idx;
  logic [W-1:0]   wr_val;
  logic [BIW-1:0] idx_m1, idx_m2;
  logic           has2, has1;

  assign idx_m1 = BIW'(lvl_q - LVW'(1));
  assign idx_m2 = BIW'(lvl_q - LVW'(2));
  assign has1   = (lvl_q >= LVW'(1));
  assign has2   = (lvl_q >= LVW'(2));
  assign nos    = has2 ? below[idx_m2] : '0;

  // next state
  always_comb begin
    tos_d  = tos_q;
    lvl_d  = lvl_q;
    wr_en  = 1'b0;
    wr_idx = idx_m1;
    wr_val = tos_q;
    if (en) begin
      unique case (act)
        SK_PUSH: begin
          wr_en = has1;
          tos_d = din;
          lvl_d = lvl_q + LVW'(1);
        end
        SK_POP: begin
          tos_d = nos;
          lvl_d = lvl_q - LVW'(1);
        end
        SK_SET: tos_d = din;
        SK_MERGE: begin
          tos_d = din;
          lvl_d = lvl_q - LVW'(1);
        end
        SK_SWAP: begin
          wr_en  = 1'b1;
          wr_idx = idx_m2;
          tos_d  = nos;
        end
        default: ;
      endcase
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tos_q <= '0;
      lvl_q <= '0;
    end else if (en) begin
      tos_q <= tos_d;
      lvl_q <= lvl_d;
    end
  end

  // storage array below the top, write-enabled, not reset
  always_ff @(posedge clk) begin
    if (wr_en) below[wr_idx] <= wr_val;
  end

  assign tos   = tos_q;
  assign level = lvl_q;

endmodule

// File: rtl/smc_core.sv
module smc_core
  import smc_pkg::*;
#(
  parameter int W      = 16,
  parameter int DEPTH  = 8,
  parameter int SLOTS  = 8,
  parameter int PDEPTH = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        prog_we,
  input  logic [$clog2(PDEPTH)-1:0]   prog_addr,
  input  logic [OPW+W-1:0]            prog_data,
  input  logic                        run,
  input  logic                        in_valid,
  input  logic [W-1:0]                in_data,
  output logic                        in_take,
  output logic                        out_valid,
  output logic [W-1:0]                out_data,
  output logic                        halted,
  output logic [1:0]                  err_code,
  output logic                        div_zero,
  output logic [$clog2(DEPTH+1)-1:0]  stk_level
);

  localparam int PAW = $clog2(PDEPTH);
  localparam int SLW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam int IW  = OPW + W;
  localparam int LVW = $clog2(DEPTH+1);

  // program memory
  logic [IW-1:0] pmem [PDEPTH];
  always_ff @(posedge clk) begin
    if (prog_we) pmem[prog_addr] <= prog_data;
  end

  logic [PAW-1:0] pc_q, pc_d;
  logic [IW-1:0]  instr;
  logic [OPW-1:0] op;
  logic [W-1:0]   arg;
  dec_t           dec;

  assign instr = pmem[pc_q];
  assign op    = instr[IW-1 -: OPW];
  assign arg   = instr[W-1:0];

  smc_decode u_dec (.op(op), .dec(dec));

  // stack
  logic [W-1:0]   tos, nos, res;
  logic [LVW-1:0] level;
  logic           go;

  smc_stack #(.W(W), .DEPTH(DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n), .en(go), .act(dec.act),
    .din(res), .tos(tos), .nos(nos), .level(level)
  );

  // arithmetic
  logic [W-1:0] alu_res;
  logic         alu_dz;
  smc_alu #(.W(W)) u_alu (
    .x(nos), .y(tos), .fn(dec.fn), .res(alu_res), .dz(alu_dz)
  );

  // storage slots
  logic [W-1:0]   slot_q [SLOTS];
  logic [SLW-1:0] slot_sel;
  logic [W-1:0]   slot_rd;
  assign slot_sel = arg[SLW-1:0];
  assign slot_rd  = slot_q[slot_sel];

  // control
  logic halted_q, halted_d;
  err_e err_q, err_d;
  logic dz_q, dz_d;
  logic ov_q, ov_d;
  logic [W-1:0] od_q, od_d;
  logic active, under, over, fault, stall, taken;
  logic slot_we;

  assign active  = run & ~halted_q;
  assign under   = (level < LVW'(dec.n_in));
  assign over    = (dec.n_out > dec.n_in) && (level == LVW'(DEPTH));
  assign fault   = active & (~dec.legal | under | over);
  assign stall   = active & ~fault & dec.rd & ~in_valid;
  assign go      = active & ~fault & ~stall;
  assign taken   = dec.jmp | (dec.jz & (tos == '0));
  assign slot_we = go & dec.sts;

  always_comb begin
    unique case (dec.rsel)
      RS_IMM:  res = arg;
      RS_SLOT: res = slot_rd;
      RS_IN:   res = in_data;
      RS_TOS:  res = tos;
      default: res = alu_res;
    endcase
  end

  // next state
  always_comb begin
    pc_d     = pc_q;
    halted_d = halted_q;
    err_d    = err_q;
    dz_d     = dz_q;
    ov_d     = 1'b0;
    od_d     = od_q;
    if (fault) begin
      halted_d = 1'b1;
      if (!dec.legal)  err_d = ERR_ILLEGAL;
      else if (under)  err_d = ERR_UNDER;
      else             err_d = ERR_OVER;
    end else if (go) begin
      pc_d = taken ? arg[PAW-1:0] : pc_q + PAW'(1);
      if (dec.halt) halted_d = 1'b1;
      if (alu_dz && dec.act == SK_MERGE) dz_d = 1'b1;
      if (dec.wr) begin
        ov_d = 1'b1;
        od_d = tos;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
      err_q    <= ERR_NONE;
      dz_q     <= 1'b0;
      ov_q     <= 1'b0;
      od_q     <= '0;
    end else begin
      pc_q     <= pc_d;
      halted_q <= halted_d;
      err_q    <= err_d;
      dz_q     <= dz_d;
      ov_q     <= ov_d;
      od_q     <= od_d;
    end
  end

  generate
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic hit;
      assign hit = slot_we && (slot_sel == SLW'(s));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   slot_q[s] <= '0;
        else if (hit) slot_q[s] <= tos;
      end
    end
  endgenerate

  assign in_take   = go & dec.rd;
  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign halted    = halted_q;
  assign err_code  = err_q;
  assign div_zero  = dz_q;
  assign stk_level = level;

endmodule

// File: rtl/smc_chk.sv
module smc_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       run,
  input logic                       in_valid,
  input logic                       in_take,
  input logic                       out_valid,
  input logic                       halted,
  input logic [1:0]                 err_code,
  input logic                       div_zero,
  input logic [$clog2(DEPTH+1)-1:0] stk_level
);

  localparam int LVW = $clog2(DEPTH+1);

  // R12
  level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stk_level <= LVW'(DEPTH));

  // R10
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R10
  halted_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (!out_valid && !in_take));

  // R11
  err_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 2'd0) |-> halted);

  // R4
  dz_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_zero |=> div_zero);

  // R9
  take_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_take |-> in_valid);

  // R14
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(stk_level));

  // R12
  full_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_level == LVW'(DEPTH)) |-> !in_take);

endmodule

bind smc_core smc_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .in_valid(in_valid),
  .in_take(in_take), .out_valid(out_valid), .halted(halted),
  .err_code(err_code), .div_zero(div_zero), .stk_level(stk_level)
);

// File: tb/smc_core_tb.sv
module smc_core_tb;

  localparam int W = 16, DEPTH = 8, SLOTS = 8, PDEPTH = 32;
  localparam int NV = 15;
  // op, x, y, expected, expected div flag
  localparam logic [53:0] VECS [NV] = '{
    {5'd2,  16'h0007, 16'h0005, 16'h000C, 1'b0},  // R3 add
    {5'd2,  16'hFFFF, 16'h0002, 16'h0001, 1'b0},  // R3 add wrap
    {5'd3,  16'h0003, 16'h0008, 16'hFFFB, 1'b0},  // R3 sub order
    {5'd3,  16'h0009, 16'h0004, 16'h0005, 1'b0},  // R3 sub
    {5'd4,  16'hF0F0, 16'h3C3C, 16'h3030, 1'b0},  // R3 and
    {5'd5,  16'h0F00, 16'h00F0, 16'h0FF0, 1'b0},  // R3 or
    {5'd6,  16'h0002, 16'h0009, 16'h0001, 1'b0},  // R3 lt true
    {5'd6,  16'h0009, 16'h0002, 16'h0000, 1'b0},  // R3 lt false
    {5'd7,  16'h0005, 16'h0005, 16'h0001, 1'b0},  // R3 eq
    {5'd8,  16'h0064, 16'h0007, 16'h000E, 1'b0},  // R4 div
    {5'd9,  16'h0064, 16'h0007, 16'h0002, 1'b0},  // R4 mod
    {5'd8,  16'h0009, 16'h0000, 16'h0000, 1'b1},  // R4 div by zero
    {5'd9,  16'h0009, 16'h0000, 16'h0000, 1'b1},  // R4 mod by zero
    {5'd10, 16'h0005, 16'h0000, 16'hFFFB, 1'b0},  // R5 neg
    {5'd11, 16'h00FF, 16'h0000, 16'hFF00, 1'b0}   // R5 not
  };

  localparam logic [4:0] PUSH = 5'd1, ADD = 5'd2, SUB = 5'd3, DIV = 5'd8,
    DUP = 5'd12, SWAP = 5'd13, JZ = 5'd14, JMP = 5'd15, LDS = 5'd16,
    STS = 5'd17, RD = 5'd18, WR = 5'd19, HALT = 5'd20;

  logic clk = 1'b0, rst_n = 1'b0, prog_we = 1'b0, run = 1'b0, in_valid = 1'b0;
  logic [4:0]    prog_addr = '0;
  logic [20:0]   prog_data = '0;
  logic [W-1:0]  in_data = '0;
  logic          in_take, out_valid, halted, div_zero;
  logic [W-1:0]  out_data;
  logic [1:0]    err_code;
  logic [3:0]    stk_level;

  int applied = 0, miscompares = 0;
  logic [W-1:0] outs [16];
  int n_outs = 0, takes = 0;

  always #5 clk = ~clk;

  smc_core #(.W(W), .DEPTH(DEPTH), .SLOTS(SLOTS), .PDEPTH(PDEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr),
    .prog_data(prog_data), .run(run), .in_valid(in_valid), .in_data(in_data),
    .in_take(in_take), .out_valid(out_valid), .out_data(out_data),
    .halted(halted), .err_code(err_code), .div_zero(div_zero),
    .stk_level(stk_level)
  );

  // output and take monitor, away from the active edge
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (n_outs < 16) outs[n_outs] = out_data;
      n_outs = n_outs + 1;
    end
    if (rst_n && in_take) takes = takes + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    applied++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report;
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
  endtask

  task automatic do_reset;
    @(negedge clk);
    run = 1'b0; in_valid = 1'b0; rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    n_outs = 0; takes = 0;
  endtask

  task automatic put(input int a, input logic [4:0] op, input logic [W-1:0] arg);
    @(negedge clk);
    prog_we = 1'b1; prog_addr = 5'(a); prog_data = {op, arg};
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic run_it;
    @(negedge clk);
    run = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (halted) break;
    end
    run = 1'b0;
  endtask

  task automatic feed(input logic [W-1:0] v);
    @(negedge clk);
    in_valid = 1'b1; in_data = v;
    #1;
    while (!in_take) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1 halted", 32'(halted), 0);
    chk("R1 err", 32'(err_code), 0);
    chk("R1 level", 32'(stk_level), 0);
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 in_take", 32'(in_take), 0);
    chk("R1 div_zero", 32'(div_zero), 0);

    // table walk: R2 R3 R4 R5
    for (int i = 0; i < NV; i++) begin
      logic [4:0] op;
      logic [W-1:0] x, y, e;
      logic dz;
      {op, x, y, e, dz} = VECS[i];
      do_reset();
      if (op == 5'd10 || op == 5'd11) begin
        put(0, PUSH, x); put(1, op, 0); put(2, WR, 0); put(3, HALT, 0);
      end else begin
        put(0, PUSH, x); put(1, PUSH, y); put(2, op, 0);
        put(3, WR, 0); put(4, HALT, 0);
      end
      run_it();
      chk("R3 result", 32'(outs[0]), 32'(e));
      chk("R4 div flag", 32'(div_zero), 32'(dz));
      chk("R10 clean halt", {28'd0, err_code, stk_level[1:0]}, 0);
    end

    // R1 slots read zero, R8 store/load
    do_reset();
    put(0, PUSH, 42); put(1, STS, 2); put(2, PUSH, 5); put(3, STS, 1);
    put(4, LDS, 2); put(5, LDS, 1); put(6, SUB, 0); put(7, WR, 0);
    put(8, LDS, 0); put(9, WR, 0); put(10, HALT, 0);
    run_it();
    chk("R8 slot load", 32'(outs[0]), 37);
    chk("R1 slot zero", 32'(outs[1]), 0);
    chk("R8 level", 32'(stk_level), 0);

    // R6 dup and swap
    do_reset();
    put(0, PUSH, 3); put(1, PUSH, 10); put(2, SWAP, 0); put(3, SUB, 0);
    put(4, DUP, 0); put(5, ADD, 0); put(6, WR, 0); put(7, HALT, 0);
    run_it();
    chk("R6 dup/swap", 32'(outs[0]), 14);

    // R7 loop: sum 3+2+1 with jz and jmp
    do_reset();
    put(0, PUSH, 3);  put(1, STS, 0);  put(2, LDS, 0);  put(3, JZ, 13);
    put(4, LDS, 1);   put(5, LDS, 0);  put(6, ADD, 0);  put(7, STS, 1);
    put(8, LDS, 0);   put(9, PUSH, 1); put(10, SUB, 0); put(11, STS, 0);
    put(12, JMP, 2);  put(13, LDS, 1); put(14, WR, 0);  put(15, HALT, 0);
    run_it();
    chk("R7 loop result", 32'(outs[0]), 6);
    chk("R7 jz pops", 32'(stk_level), 0);
    chk("R7 one output", 32'(n_outs), 1);

    // R9 streams with stall, R14 run low
    do_reset();
    put(0, RD, 0); put(1, RD, 0); put(2, ADD, 0); put(3, WR, 0); put(4, HALT, 0);
    repeat (4) @(negedge clk);
    chk("R14 idle level", 32'(stk_level), 0);
    @(negedge clk); run = 1'b1;
    repeat (4) @(negedge clk);
    chk("R9 stall no take", 32'(takes), 0);
    chk("R9 stall level", 32'(stk_level), 0);
    chk("R9 stall not halted", 32'(halted), 0);
    feed(20);
    feed(22);
    for (int c = 0; c < 20 && !halted; c++) @(negedge clk);
    run = 1'b0;
    chk("R9 stream sum", 32'(outs[0]), 42);
    chk("R9 takes", 32'(takes), 2);

    // R10 halt stops everything after it
    do_reset();
    put(0, PUSH, 1); put(1, WR, 0); put(2, HALT, 0);
    put(3, PUSH, 2); put(4, WR, 0); put(5, HALT, 0);
    run_it();
    @(negedge clk); run = 1'b1;
    repeat (5) @(negedge clk);
    run = 1'b0;
    chk("R10 single output", 32'(n_outs), 1);
    chk("R10 err none", 32'(err_code), 0);
    chk("R10 level", 32'(stk_level), 0);

    // R11 underflow
    do_reset();
    put(0, PUSH, 1); put(1, ADD, 0); put(2, HALT, 0);
    run_it();
    chk("R11 err", 32'(err_code), 1);
    chk("R11 level kept", 32'(stk_level), 1);

    // R12 overflow by push
    do_reset();
    for (int a = 0; a <= DEPTH; a++) put(a, PUSH, W'(a + 1));
    put(DEPTH + 1, HALT, 0);
    run_it();
    chk("R12 err", 32'(err_code), 2);
    chk("R12 level", 32'(stk_level), DEPTH);

    // R12 read on full stack with input offered
    do_reset();
    for (int a = 0; a < DEPTH; a++) put(a, PUSH, 7);
    put(DEPTH, RD, 0); put(DEPTH + 1, HALT, 0);
    @(negedge clk); in_valid = 1'b1; in_data = 16'h0055;
    run_it();
    in_valid = 1'b0;
    chk("R12 rd full err", 32'(err_code), 2);
    chk("R12 rd full no take", 32'(takes), 0);
    chk("R12 rd full level", 32'(stk_level), DEPTH);

    // R13 illegal opcode
    do_reset();
    put(0, PUSH, 4); put(1, 5'd31, 0); put(2, HALT, 0);
    run_it();
    chk("R13 err", 32'(err_code), 3);
    chk("R13 halted", 32'(halted), 1);

    // R4 flag sticks through later good division, cleared by reset
    do_reset();
    put(0, PUSH, 9); put(1, PUSH, 0); put(2, DIV, 0); put(3, WR, 0);
    put(4, PUSH, 4); put(5, PUSH, 2); put(6, DIV, 0); put(7, WR, 0);
    put(8, HALT, 0);
    run_it();
    chk("R4 zero result", 32'(outs[0]), 0);
    chk("R4 later quotient", 32'(outs[1]), 2);
    chk("R4 sticky", 32'(div_zero), 1);
    do_reset();
    chk("R4 reset clears", 32'(div_zero), 0);

    report();
    $finish;
  end

endmodule